// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over many clock cycles, with one adder and a set of shifting registers in place of an array of partial-product adders. When the block is idle or finished, a pulse on `start` captures both operands. The block then runs a fixed number of iterations, one for each multiplier bit. At the end it raises `done` and presents the full double-width product.

The datapath uses the wide organisation. A double-width multiplicand register starts with the operand zero-extended into its low half and moves one place left on each iteration. A single-width multiplier register moves one place right on each iteration. A double-width adder and a double-width product register complete it. A small controller spends two cycles on each iteration: a test/add cycle, then a shift cycle. The latency is therefore fixed at `2*OP_W` cycles, and it does not depend on the operand values.

Top module: `mul_shift_add`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0.
- R2: `start` is accepted only in the idle or done state. On the accepting clock edge, the product register clears to 0, the multiplicand register takes `mcandIn` zero-extended to 2*OP_W bits, and the multiplier register takes `mplrIn`. `product` reads 0 in the cycle after acceptance.
- R3: Each iteration first tests bit 0 of the multiplier register. When that bit is 1, the current multiplicand register value is added into the product register. After the test cycle of iteration k (k counted from 1), `product` equals mcandIn*(mplrIn mod 2^k). For 2 times 3 the sequence is 0, then 2, then 6, and it stays at 6.
- R4: Each iteration then shifts the multiplicand register left by one bit, filling with 0, and shifts the multiplier register right by one bit. `product` does not change during the shift cycle.
- R5: Exactly OP_W iterations are run. `done` is 0 for the first 2*OP_W-1 cycles after the accepting edge and rises on the 2*OP_W-th rising edge.
- R6: When `done` is 1, `product` equals the exact 2*OP_W-bit unsigned product of the operands, including when both operands are all ones.
- R7: `done` stays at 1 and `product` stays unchanged until a new `start` is accepted.
- R8: A `start` pulse, with any operand values, that arrives while an iteration is in progress is ignored. Neither the result nor the completion time changes.
- R9: A `start` accepted from the done state begins a new multiply, and `done` falls on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply |
| mcandIn | input | OP_W | Multiplicand operand (unsigned) |
| mplrIn | input | OP_W | Multiplier operand (unsigned) |
| product | output | 2*OP_W | Product register value |
| done | output | 1 | Result ready; held until the next accepted start |

## Verification
Because `product` is the product register itself, a fault in the test, add or shift path shows up at the port on the next test cycle. There it breaks the running partial product mcandIn*(mplrIn mod 2^k), so the bench compares it against that arithmetic value after every cycle of every multiply, and does not wait for `done`. A miscounted iteration counter shows up as `done` rising one or more cycles early or late. A busy state that wrongly accepts `start` shows up as a reloaded, zeroed product in the middle of a run. The sweep covers every operand pair of a 6-bit configuration.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEST  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } mulState_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear product
    logic add;    // product <= product + multiplicand
    logic shift;  // multiplicand << 1, multiplier >> 1
  } mulStrobe_t;

endpackage

// File: rtl/mul_adder.sv
module mul_adder #(
  parameter int W = 64
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sum
);
  // A carry out cannot occur: the running product never exceeds the final product.
  assign sum = opA + opB;
endmodule

// File: rtl/mul_dpath.sv
module mul_dpath
  import mul_pkg::*;
#(
  parameter int OP_W = 32,
  localparam int PW  = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  mulStrobe_t      strb,
  input  logic [OP_W-1:0] mcandIn,
  input  logic [OP_W-1:0] mplrIn,
  output logic            mplrLsb,
  output logic [PW-1:0]   prodOut
);

  logic [PW-1:0]   mcandQ;
  logic [OP_W-1:0] mplrQ;
  logic [PW-1:0]   prodQ;
  logic [PW-1:0]   sumW;

  mul_adder #(.W(PW)) uAdder (
    .opA (prodQ),
    .opB (mcandQ),
    .sum (sumW)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandQ <= '0;
      mplrQ  <= '0;
      prodQ  <= '0;
    end else if (strb.load) begin
      mcandQ <= {{OP_W{1'b0}}, mcandIn};
      mplrQ  <= mplrIn;
      prodQ  <= '0;
    end else begin
      if (strb.add) begin
        prodQ <= sumW;
      end
      if (strb.shift) begin
        mcandQ <= {mcandQ[PW-2:0], 1'b0};
        mplrQ  <= {1'b0, mplrQ[OP_W-1:1]};
      end
    end
  end

  assign mplrLsb = mplrQ[0];
  assign prodOut = prodQ;

  // R2: a load clears the product and zero-extends the multiplicand
  p_load_init_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (prodQ == '0) && (mcandQ[PW-1:OP_W] == '0))
    else $error("p_load_init_r2");

  // R4: shifting fills zero on the right of the multiplicand and on the left of the multiplier
  p_shift_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift && !strb.load |=> (mcandQ[0] == 1'b0) && (mplrQ[OP_W-1] == 1'b0))
    else $error("p_shift_fill_r4");

  // R4/R7: the product moves only on load or add
  p_prod_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load && !strb.add |=> $stable(prodQ))
    else $error("p_prod_hold_r7");

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int OP_W = 32,
  localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       mplrLsb,
  output mulStrobe_t strb,
  output logic       done
);

  mulState_e  state, stateNxt;
  logic [CNT_W-1:0] iterCnt;
  logic       lastIter;
  logic       accept;

  assign lastIter = (iterCnt == CNT_W'(OP_W - 1));
  assign accept   = start && ((state == ST_IDLE) || (state == ST_DONE));

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNxt = ST_TEST;
      ST_TEST:  stateNxt = ST_SHIFT;
      ST_SHIFT: stateNxt = lastIter ? ST_DONE : ST_TEST;
      ST_DONE:  if (accept) stateNxt = ST_TEST;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.load  = accept;
    strb.add   = (state == ST_TEST) && mplrLsb;
    strb.shift = (state == ST_SHIFT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      state <= stateNxt;
      if (accept) begin
        iterCnt <= '0;
      end else if (state == ST_SHIFT) begin
        iterCnt <= iterCnt + CNT_W'(1);
      end
    end
  end

  assign done = (state == ST_DONE);

  // Strobes are mutually exclusive
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.add, strb.shift}))
    else $error("p_strobe_excl_r3");

  // R5: the last shift leads to done, earlier shifts lead back to test
  p_iter_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) && lastIter |=> done)
    else $error("p_iter_limit_r5");

  p_iter_loop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) && !lastIter |=> (state == ST_TEST))
    else $error("p_iter_loop_r5");

  // R7: done holds without a start
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done)
    else $error("p_done_hold_r7");

  // R8: a busy controller never reloads
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_TEST) || (state == ST_SHIFT)) |-> !strb.load)
    else $error("p_busy_ignore_r8");

  // R9: a start accepted from done drops done on the next cycle
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    done && start |=> !done)
    else $error("p_restart_r9");

endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add
  import mul_pkg::*;
#(
  parameter int OP_W = 32,
  localparam int PW  = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] mcandIn,
  input  logic [OP_W-1:0] mplrIn,
  output logic [PW-1:0]   product,
  output logic            done
);

  mulStrobe_t strb;
  logic       mplrLsb;

  mul_ctrl #(.OP_W(OP_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mplrLsb (mplrLsb),
    .strb    (strb),
    .done    (done)
  );

  mul_dpath #(.OP_W(OP_W)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .mcandIn (mcandIn),
    .mplrIn  (mplrIn),
    .mplrLsb (mplrLsb),
    .prodOut (product)
  );

endmodule

// File: tb/tb_mul_shift_add.sv
`timescale 1ns/1ps
module tb_mul_shift_add;

  localparam int W  = 6;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  mcandIn = '0;
  logic [W-1:0]  mplrIn = '0;
  logic [PW-1:0] product;
  logic          done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mul_shift_add #(.OP_W(W)) dut (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mcandIn (mcandIn),
    .mplrIn  (mplrIn),
    .product (product),
    .done    (done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One multiply; if busyPoke, start pulses mid-run with other operands (R8)
  task automatic runMul(input int a, input int b, input bit busyPoke);
    longint   expFull;
    bit       traceOk;
    bit       doneOk;
    longint   badAct;
    longint   badExp;
    expFull = longint'(a) * longint'(b);
    @(negedge clk);
    mcandIn = W'(a);
    mplrIn  = W'(b);
    start   = 1'b1;
    @(negedge clk);                 // after the accepting edge
    start = 1'b0;
    // R2: product cleared; R9: done low after acceptance
    check(product == '0, "R2 product cleared on accept", longint'(product), 0);
    check(done == 1'b0, "R9 done low after accept", longint'(done), 0);
    traceOk = 1'b1;
    doneOk  = 1'b1;
    badAct  = 0;
    badExp  = 0;
    for (int j = 1; j <= 2 * W; j++) begin
      if (busyPoke && j == 3) begin
        start   = 1'b1;
        mcandIn = ~W'(a);
        mplrIn  = ~W'(b);
      end
      if (busyPoke && j == 4) start = 1'b0;
      @(negedge clk);               // after edge j
      begin
        int     k;
        longint part;
        k    = (j + 1) / 2;
        part = longint'(a) * longint'(b % (1 << k));
        if (longint'(product) != part && traceOk) begin
          traceOk = 1'b0;
          badAct  = longint'(product);
          badExp  = part;
        end
      end
      if (done != (j == 2 * W)) doneOk = 1'b0;
    end
    // R3/R4: running partial product after every cycle
    check(traceOk, busyPoke ? "R8 R3 R4 partial product with busy start" : "R3 R4 partial product",
          badAct, badExp);
    check(doneOk, "R5 done after exactly 2*OP_W cycles", longint'(done), 1);
    check(longint'(product) == expFull, "R6 final product", longint'(product), expFull);
  endtask

  initial begin : watchdog
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset values
    check(done == 1'b0, "R1 done at reset", longint'(done), 0);
    check(product == '0, "R1 product at reset", longint'(product), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && product == '0, "R1 idle after reset", longint'(product), 0);

    // R3: the 2 times 3 sequence 0, 2, 6
    @(negedge clk);
    mcandIn = W'(2);
    mplrIn  = W'(3);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(product == 0, "R3 2x3 step0", longint'(product), 0);
    @(negedge clk);
    check(product == 2, "R3 2x3 step1", longint'(product), 2);
    @(negedge clk);
    @(negedge clk);
    check(product == 6, "R3 2x3 step2", longint'(product), 6);
    repeat (2 * W - 3) @(negedge clk);
    check(done && product == 6, "R3 2x3 final", longint'(product), 6);

    // R7: done and product hold without start
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R7 done held", longint'(done), 1);
    check(product == 6, "R7 product held", longint'(product), 6);

    // Boundary: all ones
    runMul((1 << W) - 1, (1 << W) - 1, 1'b0);
    runMul(0, (1 << W) - 1, 1'b0);
    runMul((1 << W) - 1, 0, 1'b0);

    // R8: busy starts
    runMul(37, 45, 1'b1);
    runMul(63, 1, 1'b1);

    // Exhaustive sweep, R6
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        runMul(a, b, ((a + b) % 7) == 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule